// File: doc/BRIEF.md
# Synchronous FIFO with Selectable Registered Handshakes

A single-clock, single-writer, single-reader queue of parameterised depth and word width. The writer offers a word on `put_i`/`put_data_i` and it is accepted when `ready_o` is high in the same cycle. The reader sees `req_o` and the head word on `data_o`; `data_o` is always valid to look at without removing anything, and raising `get_i` while `req_o` is high removes the head at the next rising edge.

Two build-time switches choose how the handshake paths behave. With the request path unregistered, a word offered to an empty queue appears on the read side in the same cycle and can be taken without being stored. With the ready path unregistered, a full queue still shows `ready_o` high in a cycle where the reader takes a word, so that one word can enter and one can leave in that cycle. With either path registered, that signal depends only on the state latched at the last edge.

An optional occupancy mode reports the stored word count and two threshold flags against a runtime threshold. A second option clears the whole storage array during reset. When no word is held, the read side shows the last word removed, and this reads as zero right after reset.

Top module: `hs_fifo`

## Requirements
- R1: Words leave in the order they were accepted; while `req_o` is high from stored content, `data_o` is the oldest stored word, and this holds across pointer wrap at any depth.
- R2: A put is accepted exactly when `put_i` and `ready_o` are both high; with the ready path registered, `ready_o` is low whenever DEPTH words are stored.
- R3: With the ready path unregistered and DEPTH words stored, `ready_o` is high in any cycle where `get_i` is high, and both transfers take place, leaving the count at DEPTH.
- R4: With the request path unregistered, `put_i` on an empty queue raises `req_o` and shows `put_data_i` on `data_o` in the same cycle, and a simultaneous `get_i` consumes that word without storing it; with the request path registered, `req_o` is high only when at least one word was stored at the last edge.
- R5: When no word is presented, `data_o` shows the last word removed by a get.
- R6: After reset, with nothing presented, `data_o` reads zero whether or not storage clearing is enabled and whatever was held before.
- R7: With occupancy enabled, `occ_o` equals the number of stored words as of the last rising edge, between 0 and DEPTH.
- R8: With occupancy enabled, `afull_o` is high exactly when `occ_o` is at least DEPTH minus `thr_i`.
- R9: With occupancy enabled, `aempty_o` is high exactly when `occ_o` is at most `thr_i`.
- R10: With occupancy disabled, `occ_o`, `afull_o` and `aempty_o` are held at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| put_i | input | 1 | Writer offers a word |
| put_data_i | input | WIDTH | Word offered by the writer |
| ready_o | output | 1 | Queue can accept a word this cycle |
| req_o | output | 1 | A word is presented to the reader |
| data_o | output | WIDTH | Presented word, or last removed word when none |
| get_i | input | 1 | Reader removes the presented word |
| thr_i | input | $clog2(DEPTH+1) | Threshold for the occupancy flags |
| occ_o | output | $clog2(DEPTH+1) | Stored word count |
| afull_o | output | 1 | Occupancy at or above DEPTH minus threshold |
| aempty_o | output | 1 | Occupancy at or below threshold |

## Verification
The bench builds two copies at DEPTH 4 and WIDTH 8 from the same stimulus: one with both handshake paths unregistered, occupancy reporting on and no storage clearing, the other with both paths registered, occupancy off and storage clearing on. The small depth lets fill-past-full, drain-past-empty, put-and-get at both extremes and pointer wrap all occur within a few cycles, and lets the threshold sweep every value from 0 to DEPTH. A per-copy arithmetic queue model predicts every output in every cycle, including a mid-run reset that must bring the idle read word back to zero.

// File: rtl/hs_fifo_pkg.sv
package hs_fifo_pkg;

  // Next index in a ring of the given length.
  function automatic int unsigned wrap_inc(int unsigned idx, int unsigned len);
    return (idx + 1 >= len) ? 0 : idx + 1;
  endfunction

  typedef struct packed {
    logic push;
    logic pop;
  } xfer_t;

endpackage

// File: rtl/hs_fifo_store.sv
module hs_fifo_store #(
  parameter int unsigned DEPTH     = 4,
  parameter int unsigned WIDTH     = 8,
  parameter int unsigned AW        = 2,
  parameter bit          ZERO_INIT = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [WIDTH-1:0] rdata_o
);

  logic [WIDTH-1:0] mem_q [DEPTH];

  generate
    if (ZERO_INIT) begin : g_clr
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          for (int k = 0; k < DEPTH; k++) mem_q[k] <= '0;
        end else if (we_i) begin
          mem_q[waddr_i] <= wdata_i;
        end
      end
    end else begin : g_raw
      logic unused_rst;
      assign unused_rst = rst_ni;
      always_ff @(posedge clk_i) begin
        if (we_i) mem_q[waddr_i] <= wdata_i;
      end
    end
  endgenerate

  assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/hs_fifo_ctrl.sv
module hs_fifo_ctrl
  import hs_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned AW    = 2,
  parameter int unsigned CW    = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  xfer_t         xfer_i,
  output logic [AW-1:0] wr_ptr_o,
  output logic [AW-1:0] rd_ptr_o,
  output logic [CW-1:0] cnt_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_o <= '0;
      rd_ptr_o <= '0;
      cnt_o    <= '0;
    end else begin
      if (xfer_i.push) wr_ptr_o <= AW'(wrap_inc(32'(wr_ptr_o), DEPTH));
      if (xfer_i.pop)  rd_ptr_o <= AW'(wrap_inc(32'(rd_ptr_o), DEPTH));
      unique case ({xfer_i.push, xfer_i.pop})
        2'b10:   cnt_o <= cnt_o + 1'b1;
        2'b01:   cnt_o <= cnt_o - 1'b1;
        default: cnt_o <= cnt_o;
      endcase
    end
  end

endmodule

// File: rtl/hs_fifo_occ.sv
module hs_fifo_occ #(
  parameter int unsigned DEPTH   = 4,
  parameter int unsigned CW      = 3,
  parameter bit          USE_OCC = 1'b1
) (
  input  logic [CW-1:0] cnt_i,
  input  logic [CW-1:0] thr_i,
  output logic [CW-1:0] occ_o,
  output logic          afull_o,
  output logic          aempty_o
);

  localparam logic [CW:0] DEPTH_W = (CW+1)'(DEPTH);

  generate
    if (USE_OCC) begin : g_on
      logic [CW:0] sum;
      assign sum      = {1'b0, cnt_i} + {1'b0, thr_i};
      assign occ_o    = cnt_i;
      assign afull_o  = (sum >= DEPTH_W);
      assign aempty_o = (cnt_i <= thr_i);
    end else begin : g_off
      logic unused_occ;
      assign unused_occ = ^{cnt_i, thr_i};
      assign occ_o    = '0;
      assign afull_o  = 1'b0;
      assign aempty_o = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/hs_fifo.sv
module hs_fifo
  import hs_fifo_pkg::*;
#(
  parameter int unsigned DEPTH      = 4,
  parameter int unsigned WIDTH      = 8,
  parameter bit          SYNC_VALID = 1'b0,
  parameter bit          SYNC_READY = 1'b0,
  parameter bit          USE_OCC    = 1'b1,
  parameter bit          ZERO_INIT  = 1'b0,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             put_i,
  input  logic [WIDTH-1:0] put_data_i,
  output logic             ready_o,
  output logic             req_o,
  output logic [WIDTH-1:0] data_o,
  input  logic             get_i,
  input  logic [CW-1:0]    thr_i,
  output logic [CW-1:0]    occ_o,
  output logic             afull_o,
  output logic             aempty_o
);

  localparam logic [CW-1:0] FULL_C = CW'(DEPTH);

  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    cnt_q;
  logic [WIDTH-1:0] head, last_q;
  logic             empty, full, direct, push, pop, bypass;
  xfer_t            xfer;

  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == FULL_C);

  generate
    if (SYNC_READY) begin : g_rdy_reg
      assign ready_o = ~full;
    end else begin : g_rdy_comb
      // a get this cycle frees a slot for a same-cycle put
      assign ready_o = ~full | get_i;
    end
    if (SYNC_VALID) begin : g_vld_reg
      assign direct = 1'b0;
    end else begin : g_vld_comb
      assign direct = empty & put_i;
    end
  endgenerate

  assign req_o  = ~empty | direct;
  assign data_o = ~empty ? head : (direct ? put_data_i : last_q);

  assign push   = put_i & ready_o;
  assign pop    = get_i & req_o;
  assign bypass = direct & pop;

  assign xfer.push = push & ~bypass;
  assign xfer.pop  = pop & ~bypass;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  last_q <= '0;
    else if (pop) last_q <= data_o;
  end

  hs_fifo_ctrl #(
    .DEPTH(DEPTH), .AW(AW), .CW(CW)
  ) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .xfer_i  (xfer),
    .wr_ptr_o(wr_ptr),
    .rd_ptr_o(rd_ptr),
    .cnt_o   (cnt_q)
  );

  hs_fifo_store #(
    .DEPTH(DEPTH), .WIDTH(WIDTH), .AW(AW), .ZERO_INIT(ZERO_INIT)
  ) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (xfer.push),
    .waddr_i(wr_ptr),
    .wdata_i(put_data_i),
    .raddr_i(rd_ptr),
    .rdata_o(head)
  );

  hs_fifo_occ #(
    .DEPTH(DEPTH), .CW(CW), .USE_OCC(USE_OCC)
  ) u_occ (
    .cnt_i   (cnt_q),
    .thr_i   (thr_i),
    .occ_o   (occ_o),
    .afull_o (afull_o),
    .aempty_o(aempty_o)
  );

endmodule

// File: rtl/hs_fifo_chk.sv
module hs_fifo_chk #(
  parameter int unsigned DEPTH      = 4,
  parameter int unsigned CW         = 3,
  parameter bit          SYNC_READY = 1'b0,
  parameter bit          USE_OCC    = 1'b1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          put_i,
  input logic          get_i,
  input logic          ready_o,
  input logic          req_o,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] occ_o,
  input logic          aempty_o
);

  localparam logic [CW-1:0] FULL_C = CW'(DEPTH);

  // R7
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= FULL_C);

  // R2
  full_blocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt == FULL_C && !get_i) |-> !ready_o);

  // R4
  empty_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt == '0 && !put_i) |-> !req_o);

  // R1
  fill_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt != '0 && put_i && ready_o && !(get_i && req_o)) |=> (cnt == $past(cnt) + 1'b1));

  generate
    if (!SYNC_READY) begin : g_comb_rdy
      // R3
      full_swap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cnt == FULL_C && get_i) |-> ready_o);
    end
    if (USE_OCC) begin : g_occ
      // R9
      empty_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (occ_o == '0) |-> aempty_o);
    end
  endgenerate

endmodule

bind hs_fifo hs_fifo_chk #(
  .DEPTH(DEPTH), .CW(CW), .SYNC_READY(SYNC_READY), .USE_OCC(USE_OCC)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .put_i   (put_i),
  .get_i   (get_i),
  .ready_o (ready_o),
  .req_o   (req_o),
  .cnt     (cnt_q),
  .occ_o   (occ_o),
  .aempty_o(aempty_o)
);

// File: tb/sim_hs_fifo.sv
`timescale 1ns/1ps
module sim_hs_fifo;
  localparam int D  = 4;
  localparam int W  = 8;
  localparam int CW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          put = 1'b0, get = 1'b0;
  logic [W-1:0]  pdata = '0;
  logic [CW-1:0] thr = '0;
  logic          rdy [2], req [2], af [2], ae [2];
  logic [W-1:0]  dat [2];
  logic [CW-1:0] occ [2];

  // u0: both paths unregistered, occupancy on, no clearing
  hs_fifo #(.DEPTH(D), .WIDTH(W), .SYNC_VALID(1'b0), .SYNC_READY(1'b0),
            .USE_OCC(1'b1), .ZERO_INIT(1'b0)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .put_i(put), .put_data_i(pdata),
    .ready_o(rdy[0]), .req_o(req[0]), .data_o(dat[0]), .get_i(get),
    .thr_i(thr), .occ_o(occ[0]), .afull_o(af[0]), .aempty_o(ae[0]));

  // u1: both paths registered, occupancy off, clearing on
  hs_fifo #(.DEPTH(D), .WIDTH(W), .SYNC_VALID(1'b1), .SYNC_READY(1'b1),
            .USE_OCC(1'b0), .ZERO_INIT(1'b1)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .put_i(put), .put_data_i(pdata),
    .ready_o(rdy[1]), .req_o(req[1]), .data_o(dat[1]), .get_i(get),
    .thr_i(thr), .occ_o(occ[1]), .afull_o(af[1]), .aempty_o(ae[1]));

  int n_chk = 0, n_bad = 0;
  int m_mem [2][D];
  int m_rd [2], m_cnt [2], m_last [2];
  bit post_rst = 1'b0;
  bit done = 1'b0;
  logic [15:0] lf = 16'hACE1;

  task automatic cmp(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic mdl_clear();
    for (int i = 0; i < 2; i++) begin
      m_rd[i] = 0; m_cnt[i] = 0; m_last[i] = 0;
    end
  endtask

  task automatic step(bit p, int d, bit g, int t);
    put = p; pdata = W'(d); get = g; thr = CW'(t);
    #2;
    for (int i = 0; i < 2; i++) begin
      bit sv = (i == 1);
      bit sr = (i == 1);
      bit oe = (i == 0);
      bit e_req = (m_cnt[i] > 0) || (!sv && p);
      int e_dat = (m_cnt[i] > 0) ? m_mem[i][m_rd[i]] : ((!sv && p) ? d : m_last[i]);
      bit e_rdy = (m_cnt[i] < D) || (!sr && g);
      int e_occ = oe ? m_cnt[i] : 0;
      int e_af  = oe ? int'(m_cnt[i] >= D - t) : 0;
      int e_ae  = oe ? int'(m_cnt[i] <= t) : 0;
      bit push, pop, byp;
      string dtag;
      dtag = (m_cnt[i] > 0) ? "R1" : ((!sv && p) ? "R4" : (post_rst ? "R6" : "R5"));
      cmp("R4", $sformatf("u%0d req", i), int'(req[i]), int'(e_req));
      cmp(dtag, $sformatf("u%0d data", i), int'(dat[i]), e_dat);
      cmp((!sr && m_cnt[i] == D && g) ? "R3" : "R2", $sformatf("u%0d ready", i),
          int'(rdy[i]), int'(e_rdy));
      cmp(oe ? "R7" : "R10", $sformatf("u%0d occ", i), int'(occ[i]), e_occ);
      cmp(oe ? "R8" : "R10", $sformatf("u%0d afull", i), int'(af[i]), e_af);
      cmp(oe ? "R9" : "R10", $sformatf("u%0d aempty", i), int'(ae[i]), e_ae);
      push = p && e_rdy;
      pop  = g && e_req;
      byp  = pop && (m_cnt[i] == 0);
      if (pop) begin
        m_last[i] = e_dat;
        if (!byp) begin
          m_rd[i] = (m_rd[i] + 1) % D;
          m_cnt[i]--;
        end
      end
      if (push && !byp) begin
        m_mem[i][(m_rd[i] + m_cnt[i]) % D] = d;
        m_cnt[i]++;
      end
    end
    post_rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_reset();
    put = 1'b0; get = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    mdl_clear();
    rst_n = 1'b1;
    post_rst = 1'b1;
  endtask

  task automatic rand_run(int n);
    for (int c = 0; c < n; c++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step(lf[0] | lf[3], int'(lf[15:8]), lf[1] ^ lf[5], c % (D + 1));
    end
  endtask

  initial begin
    mdl_clear();
    @(negedge clk);
    do_reset();
    step(0, 0, 0, 0);                                          // R6 idle after reset
    for (int k = 0; k < 6; k++) step(1, 16 + k, 0, k % (D + 1)); // R2 fill past full
    for (int k = 0; k < 3; k++) step(1, 40 + k, 1, 2);         // R3 put+get at full
    for (int k = 0; k < 6; k++) step(0, 0, 1, k % (D + 1));    // R5 drain past empty
    step(0, 0, 0, 0);                                          // R5 idle shows last
    for (int k = 0; k < 3; k++) step(1, 80 + k, 1, 1);         // R4 put+get at empty
    step(1, 99, 0, 0);                                         // R4 lone put
    for (int k = 0; k < 2; k++) step(0, 0, 1, 3);
    rand_run(400);                                             // R1 wrap, R7-R9 sweep
    do_reset();
    step(0, 0, 0, 0);                                          // R6 after traffic
    rand_run(200);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R1 watchdog: got %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule